// File: doc/BRIEF.md
# ATA Task File Controller

This block is the device-side register file and command sequencer of a parallel ATA drive. A host reads and writes eight byte-wide locations through a small synchronous bus: the parameters of the next command (sector count, a 24-bit block address split over three bytes, and a device/head byte), a command port that shares its offset with the status port, an error/feature port, and a 16-bit data port. The sequencer reports its progress through the busy, ready, data-request and error status bits, and raises an interrupt line that the host clears by reading status.

Three kinds of command are carried out. The identify command is a PIO-in transfer. It presents 256 words from an internal computed word table, one word per read of the data port. The cache flush command is non-data. It holds a request to a media stub until that stub returns a done pulse. The two DMA commands check the block range against the drive capacity. If the range fits, they hold a transfer request, with a direction flag, until a DMA stub returns a done pulse. Any opcode the block does not support ends at once in an abort, and so does a range that does not fit.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status (offset 7) reads 0x40, error (offset 1) reads 0x00, the count, address and device bytes read 0x00, and the interrupt, flush request and transfer request outputs are low.
- R2: While idle, bytes written at offsets 2 (count), 3, 4, 5 (address bits 7:0, 15:8, 23:16) and 6 (device) read back as written. A write at offset 1 does not change what offset 1 reads.
- R3: Opcode 0xEC moves status to 0x48 and raises the interrupt on the next cycle. Each of the next 256 reads at offset 0 returns word i of the table, where word 85 is 0x0020 (bit 5 set: write cache enabled) and every other word is {~i[7:0], i[7:0]}. The cycle after the 256th read, status is 0x40.
- R4: A read of status at offset 7 drops the interrupt line on the next cycle.
- R5: Opcode 0xE7 shows status 0xC0 and holds the flush request high until a flush-done pulse. Then status returns to 0x40 and the interrupt rises.
- R6: Opcodes 0xC8 (device to host, direction flag 1) and 0xCA (host to device, flag 0) show status 0xC0 and hold the transfer request until a transfer-done pulse. Then status is 0x40 and the interrupt rises. A count of 0 means 256 blocks.
- R7: A DMA opcode whose address plus block count exceeds CAPACITY (65536 by default) raises no transfer request. It ends with status 0x41, error 0x04 (abort, bit 2) and the interrupt raised.
- R8: Any opcode other than 0xEC, 0xE7, 0xC8 and 0xCA, including 0xA0 and 0x06, aborts exactly as in R7.
- R9: The next accepted command clears the error bit and the abort bit.
- R10: While status shows BSY or DRQ, writes to the command port and to offsets 2 to 6 have no effect.
- R11: While device-register bit 4 is set (device 1 selected), command writes are ignored.
- R12: Reads of offset 0 outside DRQ return 0 and have no effect. Done pulses that arrive outside their own command phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; the side effects of a read take place at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| intrq | output | 1 | Interrupt request to the host |
| flush_req | output | 1 | Flush request to the media stub |
| flush_done | input | 1 | Flush complete pulse |
| xfer_req | output | 1 | DMA transfer request to the DMA stub |
| xfer_to_host | output | 1 | Direction of the transfer: 1 means device to host |
| xfer_done | input | 1 | Transfer complete pulse |

## Verification
The bench goes after the last identify word. A design with an off-by-one word counter would either hold DRQ for a 257th read or drop it one word early, and the per-cycle status compare would catch either. It places DMA ranges exactly at the capacity edge (0xFFFF+1, 0xFF00+256) and one block past it, so a comparison written as greater-or-equal would wrongly abort. It also issues commands, and writes to the parameter bytes, while the block is busy, in the data phase, and with device 1 selected; a design that does not gate these would start a second command or corrupt the registers it reads back. Finally, it checks that the interrupt both rises on an abort and falls on the cycle after a status read.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int TF_BYTE_W = 8;
    localparam int TF_WORD_W = 16;
    localparam int ID_WORDS  = 256;
    localparam int ID_IDX_W  = $clog2(ID_WORDS);
    localparam int LBA_W     = 24;

    localparam int DEV1_BIT  = 4;
    localparam int ABORT_BIT = 2;

    localparam logic [7:0] OP_IDENT  = 8'hEC;
    localparam logic [7:0] OP_FLUSH  = 8'hE7;
    localparam logic [7:0] OP_RD_DMA = 8'hC8;
    localparam logic [7:0] OP_WR_DMA = 8'hCA;

    typedef enum logic [2:0] {
        OFS_DATA    = 3'd0,
        OFS_ERRFEAT = 3'd1,
        OFS_COUNT   = 3'd2,
        OFS_ADDR0   = 3'd3,
        OFS_ADDR1   = 3'd4,
        OFS_ADDR2   = 3'd5,
        OFS_DEVSEL  = 3'd6,
        OFS_CMDSTAT = 3'd7
    } tf_ofs_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PIO,
        PH_MEDIA,
        PH_XFER
    } seq_phase_e;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic rsv4;
        logic drq;
        logic rsv2;
        logic rsv1;
        logic err;
    } tf_status_t;

    typedef struct packed {
        logic [TF_BYTE_W-1:0] count;
        logic [TF_BYTE_W-1:0] addr0;
        logic [TF_BYTE_W-1:0] addr1;
        logic [TF_BYTE_W-1:0] addr2;
        logic [TF_BYTE_W-1:0] devsel;
    } tf_regs_t;

    // Identify table entry: word 85 advertises an enabled write cache.
    function automatic logic [TF_WORD_W-1:0] ident_word(input logic [ID_IDX_W-1:0] i);
        if (i == ID_IDX_W'(85))
            return 16'h0020;
        return {~i[7:0], i[7:0]};
    endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           addr,
    input  logic [TF_BYTE_W-1:0] wdata,
    input  logic                 hold,
    output tf_regs_t             regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en && !hold) begin
            case (tf_ofs_e'(addr))
                OFS_COUNT:  regs.count  <= wdata;
                OFS_ADDR0:  regs.addr0  <= wdata;
                OFS_ADDR1:  regs.addr1  <= wdata;
                OFS_ADDR2:  regs.addr2  <= wdata;
                OFS_DEVSEL: regs.devsel <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ata_tf_idrom.sv
module ata_tf_idrom
    import ata_tf_pkg::*;
(
    input  logic [ID_IDX_W-1:0]  idx,
    output logic [TF_WORD_W-1:0] word
);

    always_comb word = ident_word(idx);

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
    import ata_tf_pkg::*;
#(
    parameter int CAPACITY = 65536
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [7:0]           cmd_code,
    input  logic                 dev1_sel,
    input  logic [LBA_W-1:0]     lba,
    input  logic [7:0]           count,
    input  logic                 data_rd,
    input  logic                 status_rd,
    input  logic                 flush_done,
    input  logic                 xfer_done,
    output seq_phase_e           phase,
    output logic [ID_IDX_W-1:0]  idx,
    output logic                 err,
    output logic                 abrt,
    output logic                 intrq,
    output logic                 to_host
);

    localparam logic [LBA_W:0]   CAP_LIM  = (LBA_W+1)'(CAPACITY);
    localparam logic [ID_IDX_W-1:0] LAST_IDX = ID_IDX_W'(ID_WORDS-1);

    logic             accept;
    logic [LBA_W:0]   blocks;
    logic [LBA_W:0]   range_end;
    logic             range_bad;

    always_comb begin
        accept    = cmd_wr && (phase == PH_IDLE) && !dev1_sel;
        blocks    = (count == 8'd0) ? (LBA_W+1)'(256) : (LBA_W+1)'(count);
        range_end = {1'b0, lba} + blocks;
        range_bad = range_end > CAP_LIM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            err     <= 1'b0;
            abrt    <= 1'b0;
            intrq   <= 1'b0;
            to_host <= 1'b0;
        end else begin
            if (status_rd)
                intrq <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        err  <= 1'b0;
                        abrt <= 1'b0;
                        case (cmd_code)
                            OP_IDENT: begin
                                phase <= PH_PIO;
                                idx   <= '0;
                                intrq <= 1'b1;
                            end
                            OP_FLUSH: phase <= PH_MEDIA;
                            OP_RD_DMA, OP_WR_DMA: begin
                                if (range_bad) begin
                                    err   <= 1'b1;
                                    abrt  <= 1'b1;
                                    intrq <= 1'b1;
                                end else begin
                                    phase   <= PH_XFER;
                                    to_host <= (cmd_code == OP_RD_DMA);
                                end
                            end
                            default: begin
                                err   <= 1'b1;
                                abrt  <= 1'b1;
                                intrq <= 1'b1;
                            end
                        endcase
                    end
                end
                PH_PIO: begin
                    if (data_rd) begin
                        if (idx == LAST_IDX)
                            phase <= PH_IDLE;
                        idx <= idx + 1'b1;
                    end
                end
                PH_MEDIA: begin
                    if (flush_done) begin
                        phase <= PH_IDLE;
                        intrq <= 1'b1;
                    end
                end
                PH_XFER: begin
                    if (xfer_done) begin
                        phase <= PH_IDLE;
                        intrq <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !cmd_wr) |=> !intrq);

    // R3
    pio_last_word_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PIO && data_rd && idx == LAST_IDX) |=> (phase == PH_IDLE));

    // R10
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_MEDIA && cmd_wr && !flush_done) |=> (phase == PH_MEDIA));

    // R7
    abort_reports_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (abrt && intrq && phase == PH_IDLE));

    // R12
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !cmd_wr) |=> (phase == PH_IDLE));

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int CAPACITY = 65536
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        intrq,
    output logic        flush_req,
    input  logic        flush_done,
    output logic        xfer_req,
    output logic        xfer_to_host,
    input  logic        xfer_done
);

    tf_regs_t              regs;
    seq_phase_e            phase;
    logic [ID_IDX_W-1:0]   idx;
    logic                  err;
    logic                  abrt;
    logic                  to_host;
    logic [TF_WORD_W-1:0]  id_word;
    tf_status_t            status;
    logic                  busy;
    logic                  cmd_wr;
    logic                  data_rd;
    logic                  status_rd;

    always_comb begin
        busy      = (phase != PH_IDLE);
        cmd_wr    = bus_wr && (tf_ofs_e'(bus_addr) == OFS_CMDSTAT);
        data_rd   = bus_rd && (tf_ofs_e'(bus_addr) == OFS_DATA);
        status_rd = bus_rd && (tf_ofs_e'(bus_addr) == OFS_CMDSTAT);
    end

    ata_tf_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .hold  (busy),
        .regs  (regs)
    );

    ata_tf_seq #(.CAPACITY(CAPACITY)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_code   (bus_wdata),
        .dev1_sel   (regs.devsel[DEV1_BIT]),
        .lba        ({regs.addr2, regs.addr1, regs.addr0}),
        .count      (regs.count),
        .data_rd    (data_rd),
        .status_rd  (status_rd),
        .flush_done (flush_done),
        .xfer_done  (xfer_done),
        .phase      (phase),
        .idx        (idx),
        .err        (err),
        .abrt       (abrt),
        .intrq      (intrq),
        .to_host    (to_host)
    );

    ata_tf_idrom u_idrom (
        .idx  (idx),
        .word (id_word)
    );

    always_comb begin
        status      = '0;
        status.bsy  = (phase == PH_MEDIA) || (phase == PH_XFER);
        status.drdy = 1'b1;
        status.drq  = (phase == PH_PIO);
        status.err  = err;
    end

    always_comb begin
        flush_req    = (phase == PH_MEDIA);
        xfer_req     = (phase == PH_XFER);
        xfer_to_host = to_host;
    end

    always_comb begin
        bus_rdata = '0;
        case (tf_ofs_e'(bus_addr))
            OFS_DATA:    bus_rdata = (phase == PH_PIO) ? id_word : '0;
            OFS_ERRFEAT: bus_rdata[ABORT_BIT] = abrt;
            OFS_COUNT:   bus_rdata[7:0] = regs.count;
            OFS_ADDR0:   bus_rdata[7:0] = regs.addr0;
            OFS_ADDR1:   bus_rdata[7:0] = regs.addr1;
            OFS_ADDR2:   bus_rdata[7:0] = regs.addr2;
            OFS_DEVSEL:  bus_rdata[7:0] = regs.devsel;
            OFS_CMDSTAT: bus_rdata[7:0] = status;
            default:     bus_rdata = '0;
        endcase
    end

    // R6
    one_request_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flush_req, xfer_req, status.drq}));

endmodule

// File: tb/ata_taskfile_ctrl_bench.sv
module ata_taskfile_ctrl_bench;

    localparam int CAP = 65536;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        intrq;
    logic        flush_req;
    logic        flush_done = 1'b0;
    logic        xfer_req;
    logic        xfer_to_host;
    logic        xfer_done = 1'b0;

    always #10 clk = ~clk;

    ata_taskfile_ctrl #(.CAPACITY(CAP)) u_ata_taskfile_ctrl (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .intrq        (intrq),
        .flush_req    (flush_req),
        .flush_done   (flush_done),
        .xfer_req     (xfer_req),
        .xfer_to_host (xfer_to_host),
        .xfer_done    (xfer_done)
    );

    // Reference model state: 0 idle, 1 data-in, 2 flushing, 3 DMA.
    int     m_mode;
    int     m_word;
    bit     m_irq, m_err, m_abort, m_dir;
    int     m_tf[8];
    int     vectors = 0;
    int     misses  = 0;
    string  tag = "R1";
    bit     finished = 0;

    function automatic int table_word(int i);
        if (i == 85) return 32;
        return ((255 - i) * 256) + i;
    endfunction

    function automatic int exp_read(int a);
        case (a)
            0: return (m_mode == 1) ? table_word(m_word) : 0;
            1: return m_abort ? 4 : 0;
            7: return 64 + ((m_mode >= 2) ? 128 : 0) + ((m_mode == 1) ? 8 : 0) + (m_err ? 1 : 0);
            default: return m_tf[a];
        endcase
    endfunction

    task automatic compare(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_abort();
        m_err = 1; m_abort = 1; m_irq = 1;
    endtask

    task automatic model_step(int a, bit w, bit r, int d, bit fd, bit xd);
        if (rst) begin
            m_mode = 0; m_word = 0; m_irq = 0; m_err = 0; m_abort = 0; m_dir = 0;
            foreach (m_tf[k]) m_tf[k] = 0;
            return;
        end
        if (r && a == 7) m_irq = 0;
        if (m_mode == 0) begin
            if (w && a >= 2 && a <= 6) m_tf[a] = d;
            if (w && a == 7 && ((m_tf[6] / 16) % 2 == 0)) begin
                m_err = 0; m_abort = 0;
                if (d == 'hEC) begin
                    m_mode = 1; m_word = 0; m_irq = 1;
                end else if (d == 'hE7) begin
                    m_mode = 2;
                end else if (d == 'hC8 || d == 'hCA) begin
                    int n;
                    int base;
                    n = (m_tf[2] == 0) ? 256 : m_tf[2];
                    base = m_tf[3] + m_tf[4] * 256 + m_tf[5] * 65536;
                    if (base + n > CAP) model_abort();
                    else begin
                        m_mode = 3; m_dir = (d == 'hC8);
                    end
                end else begin
                    model_abort();
                end
            end
        end else if (m_mode == 1) begin
            if (r && a == 0) begin
                if (m_word == 255) m_mode = 0;
                m_word = (m_word + 1) % 256;
            end
        end else if (m_mode == 2) begin
            if (fd) begin m_mode = 0; m_irq = 1; end
        end else begin
            if (xd) begin m_mode = 0; m_irq = 1; end
        end
    endtask

    task automatic step(int a, bit w, bit r, int d, bit fd, bit xd);
        @(negedge clk);
        bus_addr = 3'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(d);
        flush_done = fd; xfer_done = xd;
        #1;
        if (!rst) begin
            compare($sformatf("rdata@%0d", a), int'(bus_rdata), exp_read(a));
            compare("intrq", int'(intrq), int'(m_irq));
            compare("flush_req", int'(flush_req), int'(m_mode == 2));
            compare("xfer_req", int'(xfer_req), int'(m_mode == 3));
            if (xfer_req) compare("xfer_to_host", int'(xfer_to_host), int'(m_dir));
        end
        @(posedge clk);
        model_step(a, w, r, d, fd, xd);
    endtask

    task automatic idle();           step(7, 0, 0, 0, 0, 0); endtask
    task automatic wr(int a, int d); step(a, 1, 0, d, 0, 0); endtask
    task automatic rd(int a);        step(a, 0, 1, 0, 0, 0); endtask
    task automatic fdone();          step(7, 0, 0, 0, 1, 0); endtask
    task automatic xdone();          step(7, 0, 0, 0, 0, 1); endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog %s: actual=running expected=finished", tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        rst = 1'b1;
        repeat (3) idle();
        rst = 1'b0;
        idle(); rd(7); rd(1); rd(2); rd(6);

        tag = "R2";
        wr(2, 'h5A); wr(3, 'h12); wr(4, 'h34); wr(5, 'h00); wr(6, 'h40);
        for (int a = 2; a <= 6; a++) rd(a);
        wr(1, 'hFF); rd(1);

        tag = "R3";
        wr(7, 'hEC); idle(); rd(7);
        tag = "R4";
        idle(); rd(7);
        tag = "R10";
        wr(2, 'h77); wr(7, 'hE7); rd(2); rd(7);
        tag = "R3";
        for (int i = 0; i < 256; i++) rd(0);
        rd(7); rd(0);

        tag = "R12";
        rd(0); xdone(); fdone(); rd(7); idle();

        tag = "R5";
        wr(7, 'hE7); repeat (4) idle(); rd(7);
        tag = "R10";
        wr(7, 'hC8); wr(3, 'h99); rd(3); rd(7);
        tag = "R5";
        fdone(); idle(); rd(7); idle();

        tag = "R6";
        wr(2, 4); wr(3, 'h10); wr(4, 0); wr(5, 0);
        wr(7, 'hC8); repeat (3) idle(); rd(7); xdone(); rd(7);
        wr(7, 'hCA); idle(); xdone(); rd(7);
        wr(2, 0); wr(3, 0); wr(4, 'hFF); wr(7, 'hC8); idle(); xdone(); rd(7);

        tag = "R7";
        wr(2, 1); wr(3, 'hFF); wr(4, 'hFF); wr(5, 0);
        wr(7, 'hCA); idle(); xdone(); rd(7);
        wr(2, 2); wr(7, 'hCA); idle(); rd(1); rd(7);
        wr(5, 1); wr(2, 1); wr(7, 'hC8); idle(); rd(7); rd(1);

        tag = "R9";
        wr(7, 'hE7); rd(1); rd(7); fdone(); rd(7); rd(1);

        tag = "R8";
        wr(7, 'hA0); rd(1); rd(7);
        wr(7, 'h06); rd(7);
        wr(7, 'h00); rd(1); rd(7);

        tag = "R11";
        wr(6, 'h50); wr(7, 'hEC); rd(7); rd(0); wr(7, 'hE7); rd(7);
        wr(6, 'h40); wr(7, 'hE7); rd(7); fdone(); rd(7); idle();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule